// File: doc/BRIEF.md
# Transform Schedule Shape Configurator

This block turns a compact transform request into the schedule state a vector unit needs. The request is a 4-bit mode code, three 5-bit dimension fields (x, y, z) and a vertical-first flag. From it the block works out the element count (vlen) of a matrix-multiply, FFT, DCT/iDCT, cosine-table or parallel-reduction schedule. It also fills four 32-bit shape descriptors and merges the result into a 64-bit vector state word.

The current state word is sampled together with the request when `start_i` is taken. The counting loops run one step per cycle. `busy_o` covers the whole computation. `done_o` pulses for one cycle, in the same cycle that the new state and shapes appear on the outputs, and they then hold until the next request completes. The neighbouring index generators read the descriptors.

Shape descriptor layout (LSB = bit 0):
- [5:0] x dimension
- [11:6] y dimension
- [17:12] z dimension
- [20:18] permute
- [23:21] invert
- [27:24] offset, always 0 here
- [29:28] skip
- [31:30] submode

State word layout:
- [6:0] MAXVL
- [13:7] vlen
- [46:32] remap selectors
- [62] persistence
- [63] vertical-first

Top module: `sv_shape_cfg`

## Requirements
- R1: After reset `busy_o` and `done_o` are low and `state_o` and all four shape outputs are zero.
- R2: `start_i` while idle sets `busy_o` on the next cycle. `start_i` while busy is ignored. `done_o` is a one-cycle pulse with `busy_o` low. Outputs change only in the cycle `done_o` rises and otherwise hold.
- R3: New state bits [31:14] are zero. If sampled bit 62 was 0, bits [46:32] and 62 are zero; if it was 1 they keep the sampled value. Bits [61:47] always keep the sampled value. Bit 63 equals the vertical-first flag.
- R4: Mode 0 (matrix): vlen = (x*y*z) mod 128. Every shape has xdim=x, ydim=y and zdim=z, with the remaining fields as follows:
  - shape 0: skip 3.
  - shape 1: permute 1, skip 1.
  - shape 2: permute 1, skip 3.
  - shape 3: skip 3.
- R5: Let n be the number of consecutive one-bits of x counted upward from bit 0 (0 to 5). Modes 1, 2, 4, 10 and 12 give vlen = ((x+1)*n) mod 128.
- R6: Modes 3 and 11 start with itercount = (x+1)>>1, size = 1 and vlen = 0. The block then runs n steps. Each step adds ((itercount-1)*size) mod 128 to vlen, doubles size and halves itercount. vlen wraps mod 128.
- R7: Modes 5 and 13 start with itercount = (x+1)>>1 and vlen = 0. The block then runs n steps. Each step adds itercount to vlen and halves itercount.
- R8: Modes 6, 14 and 15 give vlen = x+1.
- R9: Mode 7 gives vlen equal to the number of (step, j) pairs with step = 1, 2, 4, … below x+1 and j = 0, 2·step, 4·step, … with j+step below x+1.
- R10: MAXVL = (vlen*m) mod 128. Here m = 1 in mode 0 and m = z+1 in every other mode.
- R11: Fields not listed below are zero, and in every case xdim = x and zdim = z. The modes are grouped here by their shape rules:
  - Mode 1: submode 1. Shape 0 has skip 0, shape 1 skip 1, shape 2 skip 2, and shape 3 is zero.
  - Modes 2, 4, 10 and 12 share a template. Its submode is 3 and permute 3 for modes 10 and 12; for modes 2 and 4 it is submode 1, permute 1 and invert 1. Its ydim is 3 for modes 4 and 12 and 1 for modes 2 and 10. From the template:
    - shape 0 takes skip 1.
    - shape 1 is the template.
    - shape 2 takes skip 2 and zdim 0.
    - shape 3 takes skip 3, but is zero for modes 4 and 12.
- R12: The same field rules as R11 apply to the remaining modes:
  - Modes 3 and 11 use ydim 2. Mode 3 has submode 1 and permute 4. Mode 11 has submode 3, permute 3 and invert 5. Shape 0 is this template, shape 1 adds skip 1, shape 2 has zdim 0, and shape 3 is zero.
  - Modes 5 and 13 use submode 1 and ydim 4; mode 5 also has invert 1. Shape 0 is this template, shape 1 has skip 2, shape 2 has skip 3, and shape 3 is zero.
  - Modes 6, 14 and 15 use ydim 5. The submode is 1 for mode 15 and 3 otherwise, and mode 14 has permute 1. Only shape 0 is set.
  - Mode 7 uses submode 2. Shape 0 has skip 0 and shape 1 has skip 1; shapes 2 and 3 are zero.
- R13: Mode codes 8 and 9 leave all four shapes zero and give vlen = 0 and MAXVL = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request; taken when idle |
| mode_i | input | 4 | Transform mode code |
| xd_i | input | 5 | x dimension field |
| yd_i | input | 5 | y dimension field |
| zd_i | input | 5 | z dimension / stride field |
| vf_i | input | 1 | Vertical-first flag |
| state_i | input | 64 | Current vector state word, sampled with the request |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| state_o | output | 64 | Updated vector state word |
| shape0_o | output | 32 | Shape descriptor 0 |
| shape1_o | output | 32 | Shape descriptor 1 |
| shape2_o | output | 32 | Shape descriptor 2 |
| shape3_o | output | 32 | Shape descriptor 3 |

## Verification
A corrupted loop counter or accumulator in the vlen engine shows up in the vlen field, and through the multiplier in MAXVL, in the same cycle as `done_o`. It can also appear as a `done_o` that arrives too late or never arrives. A wrong captured request or state word shows up as mismatching shape fields or preserved state bits at that same completion pulse. Any write outside completion is seen one cycle later as an output that changed while `done_o` was low. Long loops come from x values with many trailing ones and from the reduction mode, and random persistence bits exercise both paths of the state merge.

// File: rtl/sv_shape_pkg.sv
package sv_shape_pkg;
  localparam int DIM_W      = 5;
  localparam int FLD_W      = DIM_W + 1;
  localparam int VL_W       = 7;
  localparam int CNT_W      = $clog2(DIM_W + 1);
  localparam int XE_W       = 2 ** CNT_W;
  localparam int RED_W      = VL_W + 1;
  localparam int WIDE_W     = 3 * DIM_W + 1;
  localparam int NUM_SHAPES = 4;
  localparam int SHAPE_W    = 32;
  localparam int STATE_W    = 64;
  localparam int LOW_HI     = 31;
  localparam int REMAP_LO   = 32;
  localparam int REMAP_HI   = 46;
  localparam int PERSIST_B  = 62;
  localparam int VF_B       = 63;

  typedef logic [3:0]       mode_t;
  typedef logic [DIM_W-1:0] dim_t;
  typedef logic [VL_W-1:0]  vl_t;

  typedef enum logic [2:0] {
    K_MAT, K_LOG, K_OUTER, K_COS, K_HALF, K_RED, K_NONE
  } kind_e;

  typedef struct packed {
    logic [1:0]       submode;
    logic [1:0]       skip;
    logic [3:0]       offs;
    logic [2:0]       inv;
    logic [2:0]       perm;
    logic [FLD_W-1:0] zdim;
    logic [FLD_W-1:0] ydim;
    logic [FLD_W-1:0] xdim;
  } shape_t;

  function automatic kind_e kind_of(mode_t m);
    case (m)
      4'd0:                              return K_MAT;
      4'd1, 4'd2, 4'd4, 4'd10, 4'd12:    return K_LOG;
      4'd3, 4'd11:                       return K_OUTER;
      4'd5, 4'd13:                       return K_COS;
      4'd6, 4'd14, 4'd15:                return K_HALF;
      4'd7:                              return K_RED;
      default:                           return K_NONE;
    endcase
  endfunction
endpackage

// File: rtl/sv_vlen_engine.sv
module sv_vlen_engine
  import sv_shape_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  mode_t mode_i,
  input  dim_t  xd_i,
  input  dim_t  yd_i,
  input  dim_t  zd_i,
  output logic  valid_o,
  output vl_t   vlen_o
);
  logic             run_q;
  kind_e            kind_q;
  dim_t             x_q, y_q, z_q;
  logic [CNT_W-1:0] k_q, k_d;
  vl_t              itc_q, itc_d, size_q, size_d, acc_q, acc_d;
  logic [RED_W-1:0] stp_q, stp_d, j_q, j_d;
  logic             valid_q;
  vl_t              vlen_q;

  logic             fin;
  vl_t              res;
  logic [XE_W-1:0]  x_ext;
  logic [RED_W-1:0] n_val;
  logic             tail_one;
  logic [WIDE_W-1:0] log_prod, out_term, mat_prod;

  assign x_ext    = XE_W'(x_q);
  assign tail_one = x_ext[k_q];   // bits above DIM_W read zero and end the count
  assign n_val    = RED_W'(x_q) + 1'b1;
  assign log_prod = WIDE_W'(n_val) * WIDE_W'(k_q);
  assign out_term = WIDE_W'(itc_q - 1'b1) * WIDE_W'(size_q);
  assign mat_prod = WIDE_W'(x_q) * WIDE_W'(y_q) * WIDE_W'(z_q);

  always_comb begin
    fin    = 1'b0;
    res    = '0;
    k_d    = k_q;
    itc_d  = itc_q;
    size_d = size_q;
    acc_d  = acc_q;
    stp_d  = stp_q;
    j_d    = j_q;
    case (kind_q)
      K_MAT: begin
        fin = 1'b1;
        res = mat_prod[VL_W-1:0];
      end
      K_LOG: begin
        if (tail_one) k_d = k_q + 1'b1;
        else begin
          fin = 1'b1;
          res = log_prod[VL_W-1:0];
        end
      end
      K_OUTER: begin
        if (tail_one) begin
          k_d    = k_q + 1'b1;
          acc_d  = acc_q + out_term[VL_W-1:0];
          size_d = {size_q[VL_W-2:0], 1'b0};
          itc_d  = itc_q >> 1;
        end else begin
          fin = 1'b1;
          res = acc_q;
        end
      end
      K_COS: begin
        if (tail_one) begin
          k_d   = k_q + 1'b1;
          acc_d = acc_q + itc_q;
          itc_d = itc_q >> 1;
        end else begin
          fin = 1'b1;
          res = acc_q;
        end
      end
      K_HALF: begin
        fin = 1'b1;
        res = n_val[VL_W-1:0];
      end
      K_RED: begin
        if (stp_q < n_val) begin
          if (j_q + stp_q < n_val) begin
            acc_d = acc_q + 1'b1;
            j_d   = j_q + {stp_q[RED_W-2:0], 1'b0};
          end else begin
            stp_d = {stp_q[RED_W-2:0], 1'b0};
            j_d   = '0;
          end
        end else begin
          fin = 1'b1;
          res = acc_q;
        end
      end
      default: begin
        fin = 1'b1;
        res = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      kind_q  <= K_NONE;
      x_q     <= '0;
      y_q     <= '0;
      z_q     <= '0;
      k_q     <= '0;
      itc_q   <= '0;
      size_q  <= '0;
      acc_q   <= '0;
      stp_q   <= '0;
      j_q     <= '0;
      valid_q <= 1'b0;
      vlen_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      if (start_i) begin
        run_q  <= 1'b1;
        kind_q <= kind_of(mode_i);
        x_q    <= xd_i;
        y_q    <= yd_i;
        z_q    <= zd_i;
        k_q    <= '0;
        itc_q  <= vl_t'((RED_W'(xd_i) + 1'b1) >> 1);
        size_q <= vl_t'(1);
        acc_q  <= '0;
        stp_q  <= RED_W'(1);
        j_q    <= '0;
      end else if (run_q) begin
        k_q    <= k_d;
        itc_q  <= itc_d;
        size_q <= size_d;
        acc_q  <= acc_d;
        stp_q  <= stp_d;
        j_q    <= j_d;
        if (fin) begin
          run_q   <= 1'b0;
          valid_q <= 1'b1;
          vlen_q  <= res;
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign vlen_o  = vlen_q;

  AST_LOG_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (k_q <= CNT_W'(DIM_W))) else $error("log count overrun"); // R5
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q) else $error("valid held"); // R2
endmodule

// File: rtl/sv_shape_template.sv
module sv_shape_template
  import sv_shape_pkg::*;
(
  input  mode_t  mode_i,
  input  dim_t   xd_i,
  input  dim_t   yd_i,
  input  dim_t   zd_i,
  output shape_t shp_o [NUM_SHAPES]
);
  shape_t t;
  logic   inv_kind;

  assign inv_kind = mode_i[3];

  always_comb begin
    for (int i = 0; i < NUM_SHAPES; i++) shp_o[i] = '0;
    t      = '0;
    t.xdim = FLD_W'(xd_i);
    t.zdim = FLD_W'(zd_i);
    case (kind_of(mode_i))
      K_MAT: begin
        t.ydim = FLD_W'(yd_i);
        shp_o[0] = t;  shp_o[0].skip = 2'd3;
        shp_o[1] = t;  shp_o[1].perm = 3'd1;  shp_o[1].skip = 2'd1;
        shp_o[2] = t;  shp_o[2].perm = 3'd1;  shp_o[2].skip = 2'd3;
        shp_o[3] = t;  shp_o[3].skip = 2'd3;
      end
      K_LOG: begin
        if (mode_i == 4'd1) begin
          t.submode = 2'd1;
          shp_o[0] = t;
          shp_o[1] = t;  shp_o[1].skip = 2'd1;
          shp_o[2] = t;  shp_o[2].skip = 2'd2;
        end else begin
          t.submode = inv_kind ? 2'd3 : 2'd1;
          t.perm    = inv_kind ? 3'd3 : 3'd1;
          t.inv     = inv_kind ? 3'd0 : 3'd1;
          t.ydim    = mode_i[2] ? FLD_W'(3) : FLD_W'(1);
          shp_o[0] = t;  shp_o[0].skip = 2'd1;
          shp_o[1] = t;
          shp_o[2] = t;  shp_o[2].skip = 2'd2;  shp_o[2].zdim = '0;
          if (!mode_i[2]) begin
            shp_o[3] = t;  shp_o[3].skip = 2'd3;
          end
        end
      end
      K_OUTER: begin
        t.submode = inv_kind ? 2'd3 : 2'd1;
        t.perm    = inv_kind ? 3'd3 : 3'd4;
        t.inv     = inv_kind ? 3'd5 : 3'd0;
        t.ydim    = FLD_W'(2);
        shp_o[0] = t;
        shp_o[1] = t;  shp_o[1].skip = 2'd1;
        shp_o[2] = t;  shp_o[2].zdim = '0;
      end
      K_COS: begin
        t.submode = 2'd1;
        t.ydim    = FLD_W'(4);
        t.inv     = inv_kind ? 3'd0 : 3'd1;
        shp_o[0] = t;
        shp_o[1] = t;  shp_o[1].skip = 2'd2;
        shp_o[2] = t;  shp_o[2].skip = 2'd3;
      end
      K_HALF: begin
        t.ydim    = FLD_W'(5);
        t.perm    = (mode_i == 4'd14) ? 3'd1 : 3'd0;
        t.submode = (mode_i == 4'd15) ? 2'd1 : 2'd3;
        shp_o[0] = t;
      end
      K_RED: begin
        t.submode = 2'd2;
        shp_o[0] = t;
        shp_o[1] = t;  shp_o[1].skip = 2'd1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sv_shape_cfg.sv
module sv_shape_cfg
  import sv_shape_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [3:0]          mode_i,
  input  logic [DIM_W-1:0]    xd_i,
  input  logic [DIM_W-1:0]    yd_i,
  input  logic [DIM_W-1:0]    zd_i,
  input  logic                vf_i,
  input  logic [STATE_W-1:0]  state_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [STATE_W-1:0]  state_o,
  output logic [SHAPE_W-1:0]  shape0_o,
  output logic [SHAPE_W-1:0]  shape1_o,
  output logic [SHAPE_W-1:0]  shape2_o,
  output logic [SHAPE_W-1:0]  shape3_o
);
  logic               busy_q, done_q, take;
  mode_t              mode_q;
  dim_t               x_q, y_q, z_q;
  logic               vf_q;
  logic [STATE_W-1:0] st_q, state_q, st_next;
  logic               eng_valid;
  vl_t                eng_vlen;
  shape_t             tpl     [NUM_SHAPES];
  shape_t             shape_q [NUM_SHAPES];
  logic [FLD_W-1:0]   mult;
  logic [WIDE_W-1:0]  mv_prod;

  assign take = start_i && !busy_q;

  sv_vlen_engine u_engine (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (take),
    .mode_i  (mode_i),
    .xd_i    (xd_i),
    .yd_i    (yd_i),
    .zd_i    (zd_i),
    .valid_o (eng_valid),
    .vlen_o  (eng_vlen)
  );

  sv_shape_template u_tpl (
    .mode_i (mode_q),
    .xd_i   (x_q),
    .yd_i   (y_q),
    .zd_i   (z_q),
    .shp_o  (tpl)
  );

  assign mult    = (mode_q == 4'd0) ? FLD_W'(1) : FLD_W'(z_q) + 1'b1;
  assign mv_prod = WIDE_W'(eng_vlen) * WIDE_W'(mult);

  always_comb begin
    st_next            = st_q;
    st_next[LOW_HI:0]  = '0;
    if (!st_q[PERSIST_B]) begin
      st_next[REMAP_HI:REMAP_LO] = '0;
      st_next[PERSIST_B]         = 1'b0;
    end
    st_next[VF_B]             = vf_q;
    st_next[VL_W-1:0]         = mv_prod[VL_W-1:0];
    st_next[2*VL_W-1:VL_W]    = eng_vlen;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      mode_q  <= '0;
      x_q     <= '0;
      y_q     <= '0;
      z_q     <= '0;
      vf_q    <= 1'b0;
      st_q    <= '0;
      state_q <= '0;
    end else begin
      done_q <= eng_valid;
      if (take) begin
        busy_q <= 1'b1;
        mode_q <= mode_i;
        x_q    <= xd_i;
        y_q    <= yd_i;
        z_q    <= zd_i;
        vf_q   <= vf_i;
        st_q   <= state_i;
      end else if (eng_valid) begin
        busy_q  <= 1'b0;
        state_q <= st_next;
      end
    end
  end

  for (genvar g = 0; g < NUM_SHAPES; g++) begin : g_shape
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        shape_q[g] <= '0;
      else if (eng_valid) shape_q[g] <= tpl[g];
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign state_o  = state_q;
  assign shape0_o = shape_q[0];
  assign shape1_o = shape_q[1];
  assign shape2_o = shape_q[2];
  assign shape3_o = shape_q[3];

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("done held"); // R2
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o) else $error("done while busy"); // R2
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o) else $error("start not taken"); // R2
  AST_HOLD_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eng_valid |=> ($stable(state_o) && $stable(shape0_o) && $stable(shape3_o)))
    else $error("output moved outside completion"); // R2
  AST_MAXVL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && state_o[2*VL_W-1:VL_W] == '0) |-> (state_o[VL_W-1:0] == '0))
    else $error("maxvl without vlen"); // R10
endmodule

// File: tb/sv_shape_cfg_test.sv
module sv_shape_cfg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [4:0]  xd = '0, yd = '0, zd = '0;
  logic        vf = 1'b0;
  logic [63:0] st_in = '0;
  logic        busy, done;
  logic [63:0] st_out;
  logic [31:0] s0, s1, s2, s3;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  sv_shape_cfg uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .xd_i(xd), .yd_i(yd), .zd_i(zd), .vf_i(vf), .state_i(st_in),
    .busy_o(busy), .done_o(done), .state_o(st_out),
    .shape0_o(s0), .shape1_o(s1), .shape2_o(s2), .shape3_o(s3)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int ones_run(input int x);
    int n = 0;
    while (n < 5 && x[n]) n++;
    return n;
  endfunction

  function automatic int ref_vlen(input int m, input int x, input int y, input int z);
    int n, itc, sz, v, stp, j;
    n = ones_run(x);
    v = 0;
    case (m)
      0: v = (x * y * z) % 128;
      1, 2, 4, 10, 12: v = ((x + 1) * n) % 128;
      3, 11: begin
        itc = (x + 1) / 2; sz = 1;
        for (int i = 0; i < n; i++) begin
          v = (v + ((itc - 1) * sz) % 128) % 128;
          sz = (sz * 2) % 128; itc = itc / 2;
        end
      end
      5, 13: begin
        itc = (x + 1) / 2;
        for (int i = 0; i < n; i++) begin v = (v + itc) % 128; itc = itc / 2; end
      end
      6, 14, 15: v = x + 1;
      7: begin
        stp = 1;
        while (stp < x + 1) begin
          j = 0;
          while (j + stp < x + 1) begin j += 2 * stp; v++; end
          stp *= 2;
        end
      end
      default: v = 0;
    endcase
    return v;
  endfunction

  function automatic logic [31:0] mk(input int sm, input int sk, input int iv,
                                     input int pm, input int z6, input int y6, input int x6);
    return {sm[1:0], sk[1:0], 4'b0, iv[2:0], pm[2:0], z6[5:0], y6[5:0], x6[5:0]};
  endfunction

  function automatic logic [31:0] ref_shape(input int idx, input int m,
                                            input int x, input int y, input int z);
    int sm, pm, iv, yy;
    case (m)
      0: case (idx)
           0: return mk(0, 3, 0, 0, z, y, x);
           1: return mk(0, 1, 0, 1, z, y, x);
           2: return mk(0, 3, 0, 1, z, y, x);
           default: return mk(0, 3, 0, 0, z, y, x);
         endcase
      1: case (idx)
           0: return mk(1, 0, 0, 0, z, 0, x);
           1: return mk(1, 1, 0, 0, z, 0, x);
           2: return mk(1, 2, 0, 0, z, 0, x);
           default: return 32'h0;
         endcase
      2, 4, 10, 12: begin
        sm = (m >= 10) ? 3 : 1;
        pm = (m >= 10) ? 3 : 1;
        iv = (m >= 10) ? 0 : 1;
        yy = (m == 4 || m == 12) ? 3 : 1;
        case (idx)
          0: return mk(sm, 1, iv, pm, z, yy, x);
          1: return mk(sm, 0, iv, pm, z, yy, x);
          2: return mk(sm, 2, iv, pm, 0, yy, x);
          default: return (m == 4 || m == 12) ? 32'h0 : mk(sm, 3, iv, pm, z, yy, x);
        endcase
      end
      3, 11: begin
        sm = (m == 11) ? 3 : 1;
        pm = (m == 11) ? 3 : 4;
        iv = (m == 11) ? 5 : 0;
        case (idx)
          0: return mk(sm, 0, iv, pm, z, 2, x);
          1: return mk(sm, 1, iv, pm, z, 2, x);
          2: return mk(sm, 0, iv, pm, 0, 2, x);
          default: return 32'h0;
        endcase
      end
      5, 13: begin
        iv = (m == 5) ? 1 : 0;
        case (idx)
          0: return mk(1, 0, iv, 0, z, 4, x);
          1: return mk(1, 2, iv, 0, z, 4, x);
          2: return mk(1, 3, iv, 0, z, 4, x);
          default: return 32'h0;
        endcase
      end
      6, 14, 15:
        return (idx == 0) ? mk((m == 15) ? 1 : 3, 0, 0, (m == 14) ? 1 : 0, z, 5, x) : 32'h0;
      7: case (idx)
           0: return mk(2, 0, 0, 0, z, 0, x);
           1: return mk(2, 1, 0, 0, z, 0, x);
           default: return 32'h0;
         endcase
      default: return 32'h0;
    endcase
  endfunction

  function automatic string vl_tag(input int m);
    case (m)
      0: return "R4";
      1, 2, 4, 10, 12: return "R5";
      3, 11: return "R6";
      5, 13: return "R7";
      6, 14, 15: return "R8";
      7: return "R9";
      default: return "R13";
    endcase
  endfunction

  function automatic string sh_tag(input int m);
    case (m)
      0: return "R4";
      1, 2, 4, 10, 12: return "R11";
      8, 9: return "R13";
      default: return "R12";
    endcase
  endfunction

  task automatic run(input int m, input int x, input int y, input int z,
                     input bit v, input logic [63:0] old, input bit disturb);
    int cyc, vl, mul, mv;
    logic [63:0] exp_st, held;
    logic [31:0] got [4];
    @(negedge clk);
    mode = m[3:0]; xd = x[4:0]; yd = y[4:0]; zd = z[4:0]; vf = v; st_in = old;
    start = 1'b1;
    @(negedge clk);
    chk(busy === 1'b1, "R2", "busy after start", {63'b0, busy}, 64'd1);
    if (disturb) begin
      start = 1'b1; mode = ~m[3:0]; xd = ~x[4:0]; zd = ~z[4:0]; vf = ~v; st_in = ~old;
      @(negedge clk);
    end
    start = 1'b0;
    cyc = 0;
    while (done !== 1'b1 && cyc < 300) begin @(negedge clk); cyc++; end
    chk(cyc < 300, "R2", "completion timeout", 64'(cyc), 64'd300);
    chk(busy === 1'b0, "R2", "busy low at done", {63'b0, busy}, 64'd0);
    vl  = ref_vlen(m, x, y, z);
    mul = (m == 0) ? 1 : z + 1;
    mv  = (vl * mul) % 128;
    exp_st = old;
    exp_st[31:0] = '0;
    if (!old[62]) begin exp_st[46:32] = '0; exp_st[62] = 1'b0; end
    exp_st[63] = v;
    exp_st[6:0] = mv[6:0];
    exp_st[13:7] = vl[6:0];
    chk(st_out[13:7] == exp_st[13:7], vl_tag(m), $sformatf("vlen mode %0d x %0d", m, x),
        64'(st_out[13:7]), 64'(exp_st[13:7]));
    chk(st_out[6:0] == exp_st[6:0], "R10", $sformatf("maxvl mode %0d", m),
        64'(st_out[6:0]), 64'(exp_st[6:0]));
    chk(st_out[63:14] == exp_st[63:14], "R3", $sformatf("state merge persist %0b", old[62]),
        st_out, exp_st);
    got[0] = s0; got[1] = s1; got[2] = s2; got[3] = s3;
    for (int i = 0; i < 4; i++) begin
      chk(got[i] == ref_shape(i, m, x, y, z), sh_tag(m),
          $sformatf("shape%0d mode %0d", i, m), 64'(got[i]), 64'(ref_shape(i, m, x, y, z)));
    end
    held = st_out;
    @(negedge clk);
    chk(done === 1'b0, "R2", "done single pulse", {63'b0, done}, 64'd0);
    chk(st_out == held, "R2", "state holds after done", st_out, held);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL R2 watchdog expired: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1", "reset flags", {62'b0, busy, done}, 64'd0);
    chk(st_out === 64'd0, "R1", "reset state", st_out, 64'd0);
    chk({s0, s1, s2, s3} === 128'd0, "R1", "reset shapes", 64'(s0 | s1 | s2 | s3), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0, "R1", "idle after reset", {63'b0, busy}, 64'd0);

    // every mode with long loops, then with x = 0
    for (int m = 0; m < 16; m++) run(m, 31, 7, 3, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    for (int m = 0; m < 16; m++) run(m, 0, 5, 0, 1'b0, 64'h0, 1'b0);
    // partial trailing-one runs
    for (int m = 0; m < 16; m++) run(m, 5'b10111, 9, 31, 1'b0, 64'h4000_5555_AAAA_0000, 1'b0);
    // persistence clear vs keep
    run(3, 15, 2, 4, 1'b1, 64'h3FFF_FFFF_0000_0000, 1'b0);
    run(3, 15, 2, 4, 1'b0, 64'h7FFF_FFFF_0000_0000, 1'b0);
    // matrix wrap and reduction extremes
    run(0, 31, 31, 31, 1'b0, 64'h0, 1'b0);
    run(7, 1, 0, 31, 1'b1, 64'h0, 1'b0);
    run(7, 30, 0, 2, 1'b1, 64'h0, 1'b0);
    // start while busy must be ignored
    run(0, 3, 4, 5, 1'b1, 64'h0123_4567_89AB_CDEF, 1'b1);
    run(7, 31, 0, 1, 1'b0, 64'h4000_0000_0000_0000, 1'b1);
    run(11, 31, 1, 7, 1'b1, 64'h0, 1'b1);

    for (int r = 0; r < 200; r++) begin
      run(int'($urandom_range(15, 0)), int'($urandom_range(31, 0)),
          int'($urandom_range(31, 0)), int'($urandom_range(31, 0)),
          1'($urandom_range(1, 0)), {$urandom, $urandom}, 1'($urandom_range(3, 0) == 0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule